// File: doc/BRIEF.md
# Serial Word Memory Command Engine

This block is the device side of a four-wire serial word memory. A host selects the device, toggles a serial clock and shifts in a framed instruction MSB first. Each frame has four parts, in this order: a fixed four-bit start pattern, a four-bit opcode, an address or dummy byte and, for programming opcodes, a sixteen-bit data word. The engine keeps its storage in registers. It decodes each frame and then returns a word, programs one word, programs every word, or sets or clears a write-permission latch.

Programming is self-timed. When a programming frame is accepted, a countdown of `PROG_CYCLES` system clocks models the nonvolatile write time. During that interval the dedicated `ready` output is low. If the host keeps the device selected, the serial output shows the same status. An asynchronous-looking hardware purge input, sampled on the system clock, ends the countdown at once.

The serial pins are sampled on the system clock and must be synchronous to it. A rising serial-clock edge is taken as the first system clock at which `sck` reads high after reading low. The output enable stands in for the tri-state data pin.

Top module: `eep_serial_slave`

## Requirements
- R1: After `rst_n` is held low, `ready` is 1, `sdo_oe` is 0, the write-permission latch is clear and every word reads 16'hFFFF.
- R2: `sdi` is taken only on rising `sck` edges while `sel` is high. Bits arrive MSB first: start pattern 1010, then opcode (read 1000, write 0100, enable 0011, disable 0000, fill 0001), then an 8-bit address.
- R3: A frame whose first four bits are not 1010, or whose opcode is none of the five, changes no word and does not drive `sdo_oe`.
- R4: A write frame with the latch set stores its 16 data bits (MSB first) at the address. `ready` then falls on the second system clock after the final rising `sck` and stays low for `PROG_CYCLES` clocks.
- R5: Write and fill frames received while the latch is clear change no word and do not lower `ready`.
- R6: The enable opcode sets the latch and the disable opcode clears it. The latch stays set across accepted programming frames.
- R7: On a read, `sdo_oe` rises after the 16th rising `sck`, with `sdo` = D15. Each later rising `sck` advances one bit, so D0 is shown after the 31st rise. `sdo_oe` drops after the 32nd rise.
- R8: A fill frame with the latch set writes its data word to all 256 addresses and starts the same busy interval as a write.
- R9: While `sel` is high and programming is in progress, or an accepted programming frame has ended with `sel` still high, `sdo_oe` is 1 and `sdo` equals `ready` (0 busy, 1 ready).
- R10: Dropping `sel` before the final bit of a frame discards the frame; no word changes.
- R11: `hw_reset` high returns `ready` to 1 on the next clock, clears the latch and abandons the current frame. A word already accepted keeps its new value.
- R12: A frame whose first rising `sck` comes while programming is in progress is discarded whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sel | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial data in |
| hw_reset | input | 1 | Hardware purge, active high |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo |
| ready | output | 1 | High when no programming is in progress |

## Verification
The hardest situation to reach from the ports is a frame that begins while a programming countdown is still running. A second case is status polling that must turn from busy to ready while `sel` never drops. The bench starts a write, keeps the device selected and waits clock by clock until the model's busy window closes, so it sees `sdo` change under a held select. It then starts a new write while busy and confirms by a later read that the addressed word kept its old value. A purge is fired in the middle of a countdown, and the bench checks that `ready` recovers on the very next clock and that the latch has gone.

// File: rtl/eep_pkg.sv
// Shared opcodes, start pattern and frame states for the serial word memory.
package eep_pkg;
    typedef enum logic [3:0] {
        OP_READ  = 4'b1000,
        OP_WRITE = 4'b0100,
        OP_WREN  = 4'b0011,
        OP_WRDI  = 4'b0000,
        OP_FILL  = 4'b0001
    } eep_op_e;

    localparam logic [3:0] START_PAT = 4'b1010;

    typedef enum logic [2:0] {
        FS_HDR,
        FS_DATA,
        FS_READ,
        FS_POLL,
        FS_DONE
    } fstate_e;
endpackage

// File: rtl/eep_store.sv
// Word storage. It is register-based and reset to the erased value (all ones).
// It has one combinational read port and a single-word write or whole-array fill.
// Assumes: wr_en and fill_en are one-cycle pulses and never both high.
module eep_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Update one word on a write, or every word on a fill.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (fill_en || (wr_en && wr_addr == ADDR_W'(i)))
                mem[i] <= wr_data;
        end
    end

    // Combinational read for the serial shifter.
    assign rd_data = mem[rd_addr];

    assert_word_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

    assert_fill_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (mem[0] == $past(wr_data) && mem[DEPTH-1] == $past(wr_data)));
endmodule

// File: rtl/eep_prog_timer.sv
// Self-timed programming interval. A start pulse loads a countdown of
// PROG_CYCLES clocks, and busy is high while it is non-zero. A purge clears it.
// Assumes: PROG_CYCLES >= 1.
module eep_prog_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_reset,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] left;

    // Load on start, count down to zero, abort on purge.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_reset)
            left <= '0;
        else if (start)
            left <= CW'(PROG_CYCLES);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign busy = (left != '0);

    assert_purge_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset |=> !busy);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hw_reset) |=> busy);
endmodule

// File: rtl/eep_frame.sv
// Serial frame decoder. It finds rising sck edges while selected and shifts
// sdi in MSB first. It checks the start pattern, latches the opcode and address,
// keeps the write-permission latch, and shifts read data or status out.
// Assumes: sel, sck and sdi are synchronous to clk; DATA_W >= ADDR_W >= 4.
module eep_frame
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_reset,
    input  logic              sel,
    input  logic              sck,
    input  logic              sdi,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic              fill_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int HDR_BITS   = 8 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CW         = $clog2(FRAME_BITS + 1);

    logic              sck_q;
    logic              rise;
    logic [DATA_W-1:0] sr;
    logic [DATA_W-1:0] nxt_sr;
    logic [DATA_W-1:0] out_sr;
    logic [CW-1:0]     cnt;
    eep_op_e           op_q;
    logic              wel;
    fstate_e           state;
    logic              stat_drive;

    // Remember the last sck level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise    = sel && sck && !sck_q;
    assign nxt_sr  = {sr[DATA_W-2:0], sdi};
    assign rd_addr = nxt_sr[ADDR_W-1:0];

    // Frame sequencing, latch control and commit pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_reset) begin
            state   <= FS_HDR;
            cnt     <= '0;
            sr      <= '0;
            out_sr  <= '0;
            op_q    <= OP_WRDI;
            wel     <= 1'b0;
            wr_en   <= 1'b0;
            fill_en <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= 1'b0;
            fill_en <= 1'b0;
            if (!sel) begin
                state <= FS_HDR;
                cnt   <= '0;
            end else if (rise) begin
                sr <= nxt_sr;
                case (state)
                    FS_HDR: begin
                        cnt <= cnt + 1'b1;
                        if (busy)
                            state <= FS_DONE;
                        else if (cnt == CW'(3) && nxt_sr[3:0] != START_PAT)
                            state <= FS_DONE;
                        else if (cnt == CW'(7))
                            op_q <= eep_op_e'(nxt_sr[3:0]);
                        else if (cnt == CW'(HDR_BITS - 1)) begin
                            wr_addr <= nxt_sr[ADDR_W-1:0];
                            case (op_q)
                                OP_READ: begin
                                    out_sr <= rd_data;
                                    state  <= FS_READ;
                                end
                                OP_WRITE, OP_FILL: state <= FS_DATA;
                                OP_WREN: begin
                                    wel   <= 1'b1;
                                    state <= FS_DONE;
                                end
                                OP_WRDI: begin
                                    wel   <= 1'b0;
                                    state <= FS_DONE;
                                end
                                default: state <= FS_DONE;
                            endcase
                        end
                    end
                    FS_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CW'(FRAME_BITS - 1)) begin
                            if (wel) begin
                                wr_data <= nxt_sr;
                                wr_en   <= (op_q == OP_WRITE);
                                fill_en <= (op_q == OP_FILL);
                                state   <= FS_POLL;
                            end else begin
                                state <= FS_DONE;
                            end
                        end
                    end
                    FS_READ: begin
                        cnt    <= cnt + 1'b1;
                        out_sr <= out_sr << 1;
                        if (cnt == CW'(FRAME_BITS - 1))
                            state <= FS_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output drive: read data while reading, otherwise ready status when polled.
    assign stat_drive = sel && (busy || state == FS_POLL);
    assign sdo_oe     = (sel && state == FS_READ) || stat_drive;
    assign sdo        = (state == FS_READ) ? out_sr[DATA_W-1] : (stat_drive && !busy);

    assert_commit_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || fill_en) |-> wel);

    assert_read_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_READ && !sel) |=> !sdo_oe);
endmodule

// File: rtl/eep_serial_slave.sv
// Top of the serial word memory: frame decoder, word storage and programming
// timer. ready is the inverted busy of the timer.
// Assumes: all inputs synchronous to clk.
module eep_serial_slave #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck,
    input  logic sdi,
    input  logic hw_reset,
    output logic sdo,
    output logic sdo_oe,
    output logic ready
);
    logic              busy;
    logic              wr_en;
    logic              fill_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    eep_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset),
        .sel(sel), .sck(sck), .sdi(sdi), .busy(busy),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .fill_en(fill_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fill_en(fill_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset),
        .start(wr_en || fill_en), .busy(busy)
    );

    assign ready = !busy;

    assert_no_commit_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || fill_en) |-> !busy);
endmodule

// File: tb/sim_eep_serial_slave.sv
`timescale 1ns/1ps
module sim_eep_serial_slave;
    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0, sel = 1'b0, sck = 1'b0, sdi = 1'b0, hw_reset = 1'b0;
    logic sdo, sdo_oe, ready;

    always #4 clk = ~clk;

    eep_serial_slave #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck), .sdi(sdi),
        .hw_reset(hw_reset), .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready)
    );

    int checks = 0, fails = 0, cyc = 0;
    int busy_lo = 1, busy_hi = 0;
    bit mon_on = 0, done = 0;
    logic [15:0] mdl [256];
    bit mwel = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit mbusy();
        return (cyc >= busy_lo) && (cyc <= busy_hi);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison of ready (R4, R11).
    always @(negedge clk) begin
        #1;
        if (mon_on) chk("R4 ready per clock", {31'd0, ready}, {31'd0, !mbusy()});
    end

    // One serial bit: low phase, sample outputs, rising edge.
    task automatic bit_slot(input logic b, output logic o, output logic oe, output int t);
        @(negedge clk); sck = 1'b0; sdi = b;
        @(negedge clk); o = sdo; oe = sdo_oe; sck = 1'b1; t = cyc;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frame(input logic [3:0] st, input logic [3:0] op, input logic [7:0] ad,
                         input logic [15:0] dat, input int nbits, input bit keep,
                         output logic [15:0] rd, output logic [31:0] oem,
                         output logic end_oe, output int t_last);
        logic [31:0] bits;
        logic o, oe;
        int t;
        bits = {st, op, ad, dat};
        rd = '0; oem = '0; t_last = 0;
        @(negedge clk); sel = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            bit_slot(bits[31-i], o, oe, t);
            if (i >= 16) rd[31-i] = o;
            oem[31-i] = oe;
            t_last = t;
        end
        end_oe = sdo_oe;
        if (!keep) begin
            @(negedge clk); sck = 1'b0; sel = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic deselect();
        @(negedge clk); sck = 1'b0; sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] ad, input string req);
        logic [15:0] rd; logic [31:0] oem; logic eo; int t;
        frame(4'b1010, 4'b1000, ad, 16'h0, 32, 0, rd, oem, eo, t);
        chk(req, {16'd0, rd}, {16'd0, mdl[ad]});
        chk("R7 oe only in data slots", oem, 32'h0000FFFF);
        chk("R7 oe released after D0", {31'd0, eo}, 32'd0);
    endtask

    task automatic do_latch(input logic [3:0] op);
        logic [15:0] rd; logic [31:0] oem; logic eo; int t;
        frame(4'b1010, op, 8'h00, 16'h0, 16, 0, rd, oem, eo, t);
        mwel = (op == 4'b0011);
    endtask

    // Programming frame kept selected; returns whether the model accepted it.
    task automatic do_prog(input logic [3:0] op, input logic [7:0] ad, input logic [15:0] dat,
                           output bit acc);
        logic [15:0] rd; logic [31:0] oem; logic eo; int t; bit was_busy;
        was_busy = mbusy();
        acc = mwel && !was_busy;
        frame(4'b1010, op, ad, dat, 32, 1, rd, oem, eo, t);
        if (acc) begin
            busy_lo = t + 2;
            busy_hi = t + 1 + PROG;
            if (op == 4'b0001) begin
                for (int i = 0; i < 256; i++) mdl[i] = dat;
            end else begin
                mdl[ad] = dat;
            end
        end
        chk("R9 status drive after frame", {31'd0, sdo_oe}, {31'd0, acc || mbusy()});
        if (acc) chk("R9 status shows busy", {31'd0, sdo}, 32'd0);
    endtask

    task automatic wait_ready();
        while (mbusy()) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        bit acc;
        logic [15:0] rd; logic [31:0] oem; logic eo; int t;
        for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;
        chk("R1 ready after reset", {31'd0, ready}, 32'd1);
        chk("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);
        do_read(8'h00, "R1 erased word 00");
        do_read(8'hFF, "R7 read word FF");

        // R5: write without latch
        do_prog(4'b0100, 8'h12, 16'h1111, acc);
        deselect();
        do_read(8'h12, "R5 write ignored without latch");

        // R6 enable, R4 write, R9 polling through busy to ready
        do_latch(4'b0011);
        do_prog(4'b0100, 8'h12, 16'hA5C3, acc);
        chk("R2 write frame accepted", {31'd0, acc}, 32'd1);
        while (mbusy()) @(negedge clk);
        #2;
        chk("R9 poll turns ready", {30'd0, sdo_oe, sdo}, 32'd3);
        deselect();
        do_read(8'h12, "R4 written word");

        // R12: frame during busy is discarded
        do_prog(4'b0100, 8'h80, 16'h1234, acc);
        deselect();
        @(negedge clk); sel = 1'b1;
        @(negedge clk);
        #2;
        chk("R9 status while busy", {30'd0, sdo_oe, sdo}, 32'd2);
        sel = 1'b0;
        @(negedge clk);
        do_prog(4'b0100, 8'h81, 16'h4321, acc);
        chk("R12 model rejects", {31'd0, acc}, 32'd0);
        deselect();
        wait_ready();
        do_read(8'h81, "R12 busy frame discarded");
        do_read(8'h80, "R6 latch persists across write");

        // R3: bad start pattern, bad opcode
        frame(4'b1011, 4'b0100, 8'h12, 16'h0000, 32, 0, rd, oem, eo, t);
        chk("R3 bad start no drive", oem, 32'd0);
        frame(4'b1010, 4'b0111, 8'h12, 16'h0000, 32, 0, rd, oem, eo, t);
        chk("R3 bad opcode no drive", oem, 32'd0);
        do_read(8'h12, "R3 word unchanged");

        // R10: truncated write
        frame(4'b1010, 4'b0100, 8'h12, 16'h0F0F, 24, 0, rd, oem, eo, t);
        do_read(8'h12, "R10 truncated frame discarded");

        // R6 disable then write ignored
        do_latch(4'b0000);
        do_prog(4'b0100, 8'h12, 16'h7777, acc);
        deselect();
        do_read(8'h12, "R6 disable blocks write");

        // R8 fill
        do_latch(4'b0011);
        do_prog(4'b0001, 8'h00, 16'h5A5A, acc);
        deselect();
        wait_ready();
        do_read(8'h00, "R8 fill word 00");
        do_read(8'h7F, "R8 fill word 7F");
        do_read(8'hFF, "R8 fill word FF");

        // R11: purge mid-busy
        do_prog(4'b0100, 8'h40, 16'hBEEF, acc);
        deselect();
        repeat (20) @(negedge clk);
        hw_reset = 1'b1; busy_hi = cyc; mwel = 0;
        @(negedge clk);
        hw_reset = 1'b0;
        #2;
        chk("R11 ready after purge", {31'd0, ready}, 32'd1);
        do_read(8'h40, "R11 accepted word kept");
        do_prog(4'b0100, 8'h40, 16'h0001, acc);
        deselect();
        do_read(8'h40, "R11 latch cleared by purge");

        mon_on = 0;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule